// File: doc/BRIEF.md
# Five-Channel PWM Generator with Dead-Band and Input Capture

The block produces five pulse-width modulated outputs from one shared clock prescaler. Each channel has its own 8-bit period counter, period limit and duty compare value. The duty value is double-buffered, so a new value takes effect only when the next period begins. The counters advance once per prescaler tick, which lets software reach very low output frequencies without widening the counters.

Channels can be joined in pairs: channel 2p drives the true output and channel 2p+1 drives its complement. A dead-band of up to 255 clock cycles delays the rising edge of each output of the pair, so the two outputs are never high at the same time.

Channel 0 and channel 4 can be switched into input-capture mode. In that mode the block measures the period and the high time of an external signal in prescaler ticks. It raises a done flag after each full period and a sticky overflow flag when the count saturates.

Top module: `pwm_dz_top`

## Requirements
- R1: Each channel counter advances only on a prescaler tick. A tick occurs once every `presc_div`+1 clock cycles. One output period lasts (period+1)·(`presc_div`+1) clock cycles.
- R2: An enabled channel is high while its count is below its active duty value. The output is high for min(duty, period+1)·(`presc_div`+1) cycles in each period. Duty 0 keeps the output low. With period 255, duty 255 gives 255 of 256 counts high.
- R3: A duty written while a channel is running takes effect only at the start of the next period. The period that is already running finishes with the old duty.
- R4: A disabled channel drives its output low.
- R5: When `pair_en[p]` is set, output 2p follows channel 2p and output 2p+1 follows the inverse of channel 2p. The rising edge of each output is delayed by `pair_dead[p]` clock cycles, and the falling edge is not delayed. A high run of N cycles therefore becomes max(0, N−dead).
- R6: Both outputs of an enabled pair are never high in the same cycle.
- R7: In capture mode, `cap_period` reports the number of prescaler ticks from one detected rising edge to the next. `cap_high` reports the number of ticks from a rising edge to the following falling edge. With `presc_div`=0, both values equal clock cycles.
- R8: The first rising edge after capture mode is entered only arms the unit. Each later rising edge sets `cap_done`. A pulse on `cap_clr` clears the flag, and if a new edge arrives in the same cycle, setting wins over clearing.
- R9: If more than 255 ticks pass without a rising edge, the capture count saturates at 255 and `cap_ovf` is set. `cap_ovf` stays set until `cap_clr` is pulsed.
- R10: Capture unit 0 belongs to channel 0 and capture unit 1 belongs to channel 4. A channel in capture mode drives its PWM output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| presc_div | input | 16 | Shared prescaler divider minus one |
| ch_en | input | 5 | Per-channel enable |
| ch_period | input | 40 | Per-channel period limit; channel i is at bits [8i+7:8i] |
| ch_duty | input | 40 | Per-channel duty value (buffered); channel i is at bits [8i+7:8i] |
| pair_en | input | 2 | Pair p joins channels 2p and 2p+1 as a complementary pair |
| pair_dead | input | 16 | Dead time of pair p in clock cycles, bits [8p+7:8p] |
| cap_mode | input | 2 | Capture mode for unit 0 (channel 0) and unit 1 (channel 4) |
| cap_in | input | 2 | External capture signals (asynchronous) |
| cap_clr | input | 2 | Clear pulse for the done and overflow flags of each unit |
| pwm_out | output | 5 | PWM outputs |
| cap_period | output | 16 | Measured period of each unit, bits [8j+7:8j] |
| cap_high | output | 16 | Measured high time of each unit, bits [8j+7:8j] |
| cap_done | output | 2 | Capture-done flag of each unit |
| cap_ovf | output | 2 | Sticky capture overflow flag of each unit |

## Verification
The assertions take certain input behaviour for granted:
- A dead time changes only while its pair is disabled.
- A period limit changes only while its channel is disabled.
- The capture signal holds each level for at least two clock cycles, so the synchroniser sees every edge.

The stimulus changes configuration only right after a falling clock edge, and only with the affected pair or channel switched off. It generates capture waveforms with high and low phases of one or more whole clock cycles. The long-period overflow case is the only place where a count is allowed to exceed 255 ticks.

// File: rtl/pwm_dz_pkg.sv
package pwm_dz_pkg;
  localparam int CW = 8;
  typedef logic [CW-1:0] cnt_t;
  localparam cnt_t CNT_MAX = '1;

  function automatic logic level_high(input cnt_t cnt, input cnt_t duty);
    return cnt < duty;
  endfunction

  function automatic cnt_t sat_inc(input cnt_t v);
    return (v == CNT_MAX) ? v : cnt_t'(v + 1'b1);
  endfunction

  function automatic logic gap_elapsed(input cnt_t run, input cnt_t dt);
    return run >= dt;
  endfunction
endpackage

// File: rtl/pwm_dz_prescaler.sv
module pwm_dz_prescaler #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] div,
  output logic          tick
);
  logic [PW-1:0] pcnt_q;

  assign tick = (pcnt_q >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pcnt_q <= '0;
    else if (tick) pcnt_q <= '0;
    else           pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_dz_chan.sv
module pwm_dz_chan
  import pwm_dz_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  cnt_t period,
  input  cnt_t duty,
  output logic level
);
  cnt_t cnt_q;
  cnt_t duty_act;
  logic wrap;

  assign wrap = en & tick & (cnt_q >= period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      duty_act <= '0;
    end else if (!en) begin
      cnt_q    <= '0;
      duty_act <= duty;
    end else if (wrap) begin
      cnt_q    <= '0;
      duty_act <= duty;
    end else if (tick) begin
      cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign level = en & level_high(cnt_q, duty_act);

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(cnt_q)); // R1
  AST_DUTY_BUFFERED: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> $stable(duty_act)); // R3
endmodule

// File: rtl/pwm_dz_deadband.sv
module pwm_dz_deadband
  import pwm_dz_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_sig,
  input  cnt_t dt,
  output logic out_sig
);
  cnt_t run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_q <= '0;
    else if (!in_sig)     run_q <= '0;
    else if (run_q < dt)  run_q <= run_q + 1'b1;
  end

  assign out_sig = in_sig & gap_elapsed(run_q, dt);

  AST_RISE_DELAYED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_sig) && dt != '0) |-> $past(in_sig)); // R5
endmodule

// File: rtl/pwm_dz_capture.sv
module pwm_dz_capture
  import pwm_dz_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic mode,
  input  logic sig_in,
  input  logic clr,
  output cnt_t period_q,
  output cnt_t high_q,
  output logic done,
  output logic ovf
);
  logic [1:0] sync_q;
  logic       prev_q;
  logic       armed_q;
  cnt_t       cnt_q;
  logic       rise, fall, sat_hit;

  assign rise    = sync_q[1] & ~prev_q;
  assign fall    = ~sync_q[1] & prev_q;
  assign sat_hit = armed_q & tick & ~rise & (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      prev_q   <= 1'b0;
      armed_q  <= 1'b0;
      cnt_q    <= '0;
      period_q <= '0;
      high_q   <= '0;
      done     <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], sig_in};
      prev_q <= sync_q[1];
      if (!mode) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
        done    <= 1'b0;
        ovf     <= 1'b0;
      end else begin
        if (clr) begin
          done <= 1'b0;
          ovf  <= 1'b0;
        end
        if (rise) begin
          if (armed_q) begin
            period_q <= cnt_q;
            done     <= 1'b1;
          end
          armed_q <= 1'b1;
          cnt_q   <= tick ? cnt_t'(1) : '0;
        end else if (armed_q && tick) begin
          if (cnt_q == CNT_MAX) ovf <= 1'b1;
          cnt_q <= sat_inc(cnt_q);
        end
        if (fall && armed_q) high_q <= cnt_q;
      end
    end
  end

  AST_DONE_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rise)); // R8
  AST_OVF_ON_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && sat_hit) |=> ovf); // R9
endmodule

// File: rtl/pwm_dz_top.sv
module pwm_dz_top
  import pwm_dz_pkg::*;
#(
  parameter int NCH = 5,
  parameter int PW  = 16,
  localparam int NPAIR = NCH / 2,
  localparam int NCAP  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PW-1:0]       presc_div,
  input  logic [NCH-1:0]      ch_en,
  input  logic [NCH*CW-1:0]   ch_period,
  input  logic [NCH*CW-1:0]   ch_duty,
  input  logic [NPAIR-1:0]    pair_en,
  input  logic [NPAIR*CW-1:0] pair_dead,
  input  logic [NCAP-1:0]     cap_mode,
  input  logic [NCAP-1:0]     cap_in,
  input  logic [NCAP-1:0]     cap_clr,
  output logic [NCH-1:0]      pwm_out,
  output logic [NCAP*CW-1:0]  cap_period,
  output logic [NCAP*CW-1:0]  cap_high,
  output logic [NCAP-1:0]     cap_done,
  output logic [NCAP-1:0]     cap_ovf
);
  localparam int CAP_LAST = NCH - 1;

  logic             tick;
  logic [NCH-1:0]   raw;
  logic [NCH-1:0]   en_eff;
  logic [NCH-1:0]   cap_mask;
  logic [NPAIR-1:0] db_a, db_b;

  pwm_dz_prescaler #(.PW(PW)) u_presc (
    .clk(clk), .rst_n(rst_n), .div(presc_div), .tick(tick)
  );

  always_comb begin
    cap_mask           = '0;
    cap_mask[0]        = cap_mode[0];
    cap_mask[CAP_LAST] = cap_mode[1];
    en_eff             = ch_en & ~cap_mask;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_dz_chan u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(en_eff[g]),
      .period(ch_period[g*CW +: CW]), .duty(ch_duty[g*CW +: CW]),
      .level(raw[g])
    );
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic a_in, b_in;
    assign a_in = pair_en[p] & raw[2*p];
    assign b_in = pair_en[p] & en_eff[2*p] & ~raw[2*p];

    pwm_dz_deadband u_db_a (
      .clk(clk), .rst_n(rst_n), .in_sig(a_in),
      .dt(pair_dead[p*CW +: CW]), .out_sig(db_a[p])
    );
    pwm_dz_deadband u_db_b (
      .clk(clk), .rst_n(rst_n), .in_sig(b_in),
      .dt(pair_dead[p*CW +: CW]), .out_sig(db_b[p])
    );

    AST_PAIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      pair_en[p] |-> !(pwm_out[2*p] && pwm_out[2*p+1])); // R6
  end

  for (genvar j = 0; j < NCAP; j++) begin : g_cap
    pwm_dz_capture u_cap (
      .clk(clk), .rst_n(rst_n), .tick(tick), .mode(cap_mode[j]),
      .sig_in(cap_in[j]), .clr(cap_clr[j]),
      .period_q(cap_period[j*CW +: CW]), .high_q(cap_high[j*CW +: CW]),
      .done(cap_done[j]), .ovf(cap_ovf[j])
    );
  end

  always_comb begin
    pwm_out = raw;
    for (int p = 0; p < NPAIR; p++) begin
      if (pair_en[p]) begin
        pwm_out[2*p]   = db_a[p];
        pwm_out[2*p+1] = db_b[p];
      end
    end
    if (cap_mode[0]) pwm_out[0]        = 1'b0;
    if (cap_mode[1]) pwm_out[CAP_LAST] = 1'b0;
  end
endmodule

// File: tb/pwm_dz_top_tb_top.sv
`timescale 1ns/1ps
module pwm_dz_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] presc_div = '0;
  logic [4:0]  ch_en = '0;
  logic [39:0] ch_period = '0;
  logic [39:0] ch_duty = '0;
  logic [1:0]  pair_en = '0;
  logic [15:0] pair_dead = '0;
  logic [1:0]  cap_mode = '0;
  logic [1:0]  cap_in = '0;
  logic [1:0]  cap_clr = '0;
  logic [4:0]  pwm_out;
  logic [15:0] cap_period, cap_high;
  logic [1:0]  cap_done, cap_ovf;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int hi_cnt[5];
  int both_cnt[2];

  always #2.5 clk = ~clk;

  pwm_dz_top dut_i (
    .clk(clk), .rst_n(rst_n), .presc_div(presc_div), .ch_en(ch_en),
    .ch_period(ch_period), .ch_duty(ch_duty), .pair_en(pair_en),
    .pair_dead(pair_dead), .cap_mode(cap_mode), .cap_in(cap_in),
    .cap_clr(cap_clr), .pwm_out(pwm_out), .cap_period(cap_period),
    .cap_high(cap_high), .cap_done(cap_done), .cap_ovf(cap_ovf)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_window(input int ncyc);
    for (int i = 0; i < 5; i++) hi_cnt[i] = 0;
    both_cnt[0] = 0; both_cnt[1] = 0;
    repeat (ncyc) begin
      @(negedge clk);
      for (int i = 0; i < 5; i++) if (pwm_out[i]) hi_cnt[i]++;
      for (int p = 0; p < 2; p++)
        if (pair_en[p] && pwm_out[2*p] && pwm_out[2*p+1]) both_cnt[p]++;
    end
  endtask

  task automatic wait_rise(input int ch);
    logic prev;
    @(negedge clk);
    prev = pwm_out[ch];
    while (1) begin
      @(negedge clk);
      if (!prev && pwm_out[ch]) break;
      prev = pwm_out[ch];
    end
  endtask

  task automatic run_len(input int ch, output int n);
    n = 0;
    while (pwm_out[ch]) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic cap_pulses(input int j, input int h, input int l, input int n);
    repeat (n) begin
      cap_in[j] = 1'b1;
      repeat (h) @(negedge clk);
      cap_in[j] = 1'b0;
      repeat (l) @(negedge clk);
    end
  endtask

  task automatic cap_restart(input int j);
    cap_mode[j] = 1'b0;
    @(negedge clk);
    cap_mode[j] = 1'b1;
    @(negedge clk);
  endtask

  task automatic cap_clear(input int j);
    cap_clr[j] = 1'b1;
    @(negedge clk);
    cap_clr[j] = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int n, e, sum;
    repeat (4) @(negedge clk);
    check("R4 reset outputs low", pwm_out, 0);
    check("R8 reset done clear", cap_done, 0);
    check("R9 reset ovf clear", cap_ovf, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: disabled channels stay low although duty is set
    for (int i = 0; i < 5; i++) begin
      ch_period[i*8 +: 8] = 8'd15;
      ch_duty[i*8 +: 8]   = 8'd8;
    end
    run_window(64);
    sum = 0;
    for (int i = 0; i < 5; i++) sum += hi_cnt[i];
    check("R4 disabled channels low", sum, 0);

    // R2: duty sweep on all five channels, period 15, no prescale
    ch_en = 5'b11111;
    for (int d = 0; d < 18; d++) begin
      for (int i = 0; i < 5; i++) ch_duty[i*8 +: 8] = 8'((d + 3*i) % 18);
      run_window(40);
      run_window(64);
      for (int i = 0; i < 5; i++) begin
        e = (d + 3*i) % 18;
        if (e > 16) e = 16;
        check($sformatf("R2 duty ch%0d d=%0d", i, (d + 3*i) % 18), hi_cnt[i], 4*e);
      end
    end

    // R1: prescaler sweep, period 7, duty 3
    for (int k = 0; k < 4; k++) begin
      int dv;
      dv = (k == 3) ? 4 : k + 1;
      ch_en = '0;
      @(negedge clk);
      presc_div = 16'(dv);
      for (int i = 0; i < 5; i++) begin
        ch_period[i*8 +: 8] = 8'd7;
        ch_duty[i*8 +: 8]   = 8'd3;
      end
      ch_en = 5'b00100;
      run_window(16*(dv+1));
      run_window(16*(dv+1));
      check($sformatf("R1 prescale div=%0d high", dv), hi_cnt[2], 6*(dv+1));
      e = 0;
      for (int c = 0; c < 8*(dv+1); c++) begin
        @(negedge clk);
        if (pwm_out[2]) e++;
      end
      check($sformatf("R1 prescale div=%0d period", dv), e, 3*(dv+1));
    end

    // R2: full scale period 255
    ch_en = '0;
    @(negedge clk);
    presc_div = '0;
    ch_period[2*8 +: 8] = 8'd255;
    ch_duty[2*8 +: 8]   = 8'd255;
    ch_en = 5'b00100;
    run_window(300);
    run_window(512);
    check("R2 duty 255 of 256", hi_cnt[2], 510);
    ch_duty[2*8 +: 8] = 8'd0;
    run_window(600);
    run_window(512);
    check("R2 duty zero low", hi_cnt[2], 0);

    // R3: duty change mid period
    ch_en = '0;
    @(negedge clk);
    ch_period[2*8 +: 8] = 8'd15;
    ch_duty[2*8 +: 8]   = 8'd8;
    ch_en = 5'b00100;
    run_window(40);
    wait_rise(2);
    ch_duty[2*8 +: 8] = 8'd3;
    run_len(2, n);
    check("R3 running period keeps old duty", n, 8);
    wait_rise(2);
    run_len(2, n);
    check("R3 next period uses new duty", n, 3);

    // R5/R6: complementary pair 0 with dead time sweep
    for (int di = 0; di < 3; di++) begin
      for (int ti = 0; ti < 4; ti++) begin
        int d, t, ea, eb;
        d = 4 + 4*di;
        t = (ti == 3) ? 5 : ti;
        ch_en = '0; pair_en = '0;
        @(negedge clk);
        ch_duty[0 +: 8] = 8'(d);
        ch_period[0 +: 8] = 8'd15;
        pair_dead[0 +: 8] = 8'(t);
        ch_en = 5'b00001; pair_en = 2'b01;
        run_window(40);
        run_window(64);
        ea = (d - t > 0) ? d - t : 0;
        eb = (16 - d - t > 0) ? 16 - d - t : 0;
        check($sformatf("R5 pair true d=%0d dt=%0d", d, t), hi_cnt[0], 4*ea);
        check($sformatf("R5 pair compl d=%0d dt=%0d", d, t), hi_cnt[1], 4*eb);
        check($sformatf("R6 pair overlap d=%0d dt=%0d", d, t), both_cnt[0], 0);
      end
    end

    // R5/R6: pair 1 on channels 2 and 3
    ch_en = '0; pair_en = '0;
    @(negedge clk);
    ch_period[2*8 +: 8] = 8'd15;
    ch_duty[2*8 +: 8]   = 8'd6;
    pair_dead[8 +: 8]   = 8'd2;
    ch_en = 5'b00100; pair_en = 2'b10;
    run_window(40);
    run_window(64);
    check("R5 pair1 true", hi_cnt[2], 16);
    check("R5 pair1 compl", hi_cnt[3], 32);
    check("R6 pair1 overlap", both_cnt[1], 0);

    // R10: capture mode forces channel 0 and channel 4 low
    ch_en = '0; pair_en = '0;
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      ch_period[i*8 +: 8] = 8'd15;
      ch_duty[i*8 +: 8]   = 8'd8;
    end
    ch_en = 5'b11111;
    cap_mode = 2'b11;
    run_window(40);
    run_window(64);
    check("R10 ch0 low in capture", hi_cnt[0], 0);
    check("R10 ch4 low in capture", hi_cnt[4], 0);
    check("R10 ch2 unaffected", hi_cnt[2], 32);
    ch_en = '0;

    // R7: capture sweep on both units
    for (int j = 0; j < 2; j++) begin
      for (int hi = 0; hi < 4; hi++) begin
        for (int li = 0; li < 3; li++) begin
          int h, l;
          h = (hi == 0) ? 2 : (hi == 1) ? 3 : (hi == 2) ? 7 : 20;
          l = (li == 0) ? 2 : (li == 1) ? 5 : 30;
          cap_restart(j);
          cap_pulses(j, h, l, 2);
          repeat (4) @(negedge clk);
          check($sformatf("R7 unit%0d period h=%0d l=%0d", j, h, l), cap_period[j*8 +: 8], h + l);
          check($sformatf("R7 unit%0d high h=%0d l=%0d", j, h, l), cap_high[j*8 +: 8], h);
          check($sformatf("R8 unit%0d done h=%0d l=%0d", j, h, l), cap_done[j], 1);
          check($sformatf("R9 unit%0d no ovf h=%0d l=%0d", j, h, l), cap_ovf[j], 0);
        end
      end
    end

    // R8: first edge only arms; later edge sets; clear pulse
    cap_restart(0);
    cap_pulses(0, 5, 5, 1);
    repeat (4) @(negedge clk);
    check("R8 first edge arms only", cap_done[0], 0);
    cap_pulses(0, 5, 5, 1);
    repeat (4) @(negedge clk);
    check("R8 second edge sets done", cap_done[0], 1);
    check("R7 period including idle gap", cap_period[7:0], 14);
    cap_clear(0);
    check("R8 clear pulse", cap_done[0], 0);

    // R9: overflow saturates and sticks
    cap_restart(1);
    cap_pulses(1, 10, 300, 2);
    repeat (4) @(negedge clk);
    check("R9 ovf set", cap_ovf[1], 1);
    check("R9 period saturated", cap_period[15:8], 255);
    check("R7 high with long low", cap_high[15:8], 10);
    cap_pulses(1, 5, 5, 2);
    repeat (4) @(negedge clk);
    check("R9 ovf sticky", cap_ovf[1], 1);
    check("R7 period after ovf", cap_period[15:8], 10);
    cap_clear(1);
    check("R9 ovf cleared", cap_ovf[1], 0);
    check("R8 done cleared with ovf", cap_done[1], 0);
    cap_pulses(1, 5, 5, 2);
    repeat (4) @(negedge clk);
    check("R9 ovf stays clear", cap_ovf[1], 0);
    check("R8 done after clear", cap_done[1], 1);

    finish_run();
  end
endmodule